// File: doc/BRIEF.md
# PLL Retune Sequencer

This block retunes one PLL to a requested output frequency. A start strobe carries a target rate in MHz. The block chooses the closest supported operating point from a table built into the design and writes the matching control word onto a register-style output. It then lets a fixed settle window run and judges the PLL status inputs. It finishes with a single-cycle done pulse and a result code that says whether the PLL locked cleanly, never locked, or locked with an error flag raised.

An elaboration option selects a core-clock variant. In that variant the block also drives a select for an interface clock divider, and the order of that select against the control write depends on whether the chosen rate lies above or below a 500 MHz threshold. Independently of any retune, a combinational readback converts the current control word back into an output frequency in Hz. The readback takes the power-down and bypass bits into account. The analog PLL sits outside the block, and its lock and error indications arrive as plain inputs.

Top module: `pll_retune_ctrl`

## Requirements
- R1: A written control word places the output divider code at bits 3:2, the input divider code at bits 8:4, the feedback divider code at bits 15:9 and a band field (always zero) from bit 20; every other bit is zero.
- R2: Every newly written control word has power-down (bit 0) and bypass (bit 1) cleared.
- R3: `freq_hz` is 0 when bit 0 of the control word is set, 33333333 when bit 1 is set (and bit 0 clear), and otherwise floor(33333333 × 2 × (fb+1) / ((id+1) × 2^od)).
- R4: The chosen entry is the one whose rate is nearest to the request by absolute difference; on an equal distance the lower-rate (earlier) entry is kept. The default table is 100,125,133,150,200,233,300,333,400 MHz and then 500 to 1600 MHz in 100 MHz steps, e.g. 100 MHz = (id 0, fb 11, od 3), 800 MHz = (0, 23, 1).
- R5: The lock window lasts LOCK_US × CYCLES_PER_US cycles after the control write; done rises LOCK_US × CYCLES_PER_US + 3 clock edges after the edge that accepts the start strobe.
- R6: At the end of the window, status bit 0 (lock) clear gives result 1 (timeout), whatever bit 1 holds; lock set with status bit 1 (error) set gives result 2 (invalid); otherwise the result is 0 (OK).
- R7: In core mode, when the chosen rate is above 500 MHz, `if_div2` is already 1 in the cycle before the control word changes.
- R8: In core mode, when the chosen rate is 500 MHz or below, `if_div2` falls to 0 only together with a done whose result is OK; a timeout or invalid result leaves it unchanged.
- R9: While `busy` is high, start strobes are ignored: the control word written and the single done belong to the request that was accepted first.
- R10: With an empty table (NUM_ENTRIES = 0), a start gives done with result 2 one edge after acceptance, and the control word is not written.
- R11: Without core mode, `if_div2` stays 0.
- R12: `done` is high for exactly one cycle, and `result` holds its value until the next done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a retune; sampled only while idle |
| req_mhz | input | REQ_W | Requested output rate in MHz |
| pll_status | input | 2 | Bit 0 lock, bit 1 error, from the PLL |
| busy | output | 1 | A retune is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 OK, 1 timeout, 2 invalid |
| ctrl_word | output | CW_W | PLL control register value |
| if_div2 | output | 1 | Interface divider select: 1 divide-by-2, 0 divide-by-1 |
| freq_hz | output | FREQ_W | Frequency decoded from the control word |

## Verification
The collision of interest is a fresh start strobe landing in the same cycle as the end of a retune: the status check that raises done, or the settle count still running. The bench holds start high for the whole of a retune, with a different rate on the request lines, and releases it in the cycle where done is seen. The run passes when the control word matches the first request, exactly one done pulse appears, and busy stays low afterwards. A separate sweep over requests from 0 to above 1700 MHz checks table selection, word layout, readback and divider order against arithmetic done in the bench.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

   localparam int MHZ_W    = 11;
   localparam int PD_BIT   = 0;
   localparam int BYP_BIT  = 1;
   localparam int OD_LSB   = 2;
   localparam int OD_W     = 2;
   localparam int ID_LSB   = 4;
   localparam int ID_W     = 5;
   localparam int FB_LSB   = 9;
   localparam int FB_W     = 7;
   localparam int BAND_LSB = 20;
   localparam int TABLE_MAX = 21;

   typedef struct packed {
      logic [MHZ_W-1:0] mhz;
      logic [ID_W-1:0]  id;
      logic [FB_W-1:0]  fb;
      logic [OD_W-1:0]  od;
   } rate_entry_t;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_TIMEOUT = 2'd1,
      RES_INVALID = 2'd2
   } result_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_PREP, ST_WRITE, ST_WAIT, ST_CHECK
   } state_t;

   // Operating points, ascending by rate. The upper run is regular and computed.
   function automatic rate_entry_t table_entry(input int idx);
      rate_entry_t e;
      e = '0;
      case (idx)
         0:  e = '{mhz: 11'd100, id: 5'd0, fb: 7'd11, od: 2'd3};
         1:  e = '{mhz: 11'd125, id: 5'd0, fb: 7'd14, od: 2'd3};
         2:  e = '{mhz: 11'd133, id: 5'd0, fb: 7'd15, od: 2'd3};
         3:  e = '{mhz: 11'd150, id: 5'd0, fb: 7'd17, od: 2'd3};
         4:  e = '{mhz: 11'd200, id: 5'd1, fb: 7'd47, od: 2'd3};
         5:  e = '{mhz: 11'd233, id: 5'd1, fb: 7'd27, od: 2'd2};
         6:  e = '{mhz: 11'd300, id: 5'd1, fb: 7'd35, od: 2'd2};
         7:  e = '{mhz: 11'd333, id: 5'd1, fb: 7'd39, od: 2'd2};
         8:  e = '{mhz: 11'd400, id: 5'd1, fb: 7'd47, od: 2'd2};
         9:  e = '{mhz: 11'd500, id: 5'd0, fb: 7'd14, od: 2'd1};
         10: e = '{mhz: 11'd600, id: 5'd0, fb: 7'd17, od: 2'd1};
         11: e = '{mhz: 11'd700, id: 5'd0, fb: 7'd20, od: 2'd1};
         12: e = '{mhz: 11'd800, id: 5'd0, fb: 7'd23, od: 2'd1};
         default: begin
            if (idx >= 13 && idx < TABLE_MAX) begin
               e.mhz = MHZ_W'(900 + 100 * (idx - 13));
               e.id  = 5'd1;
               e.fb  = FB_W'(26 + 3 * (idx - 13));
               e.od  = 2'd0;
            end
         end
      endcase
      return e;
   endfunction

endpackage

// File: rtl/pll_rate_pick.sv
module pll_rate_pick
   import pll_retune_pkg::*;
#(
   parameter int NUM_ENTRIES = TABLE_MAX,
   parameter int REQ_W       = MHZ_W
) (
   input  logic [REQ_W-1:0] req,
   output logic             found,
   output rate_entry_t      pick
);

   if (NUM_ENTRIES > TABLE_MAX || NUM_ENTRIES < 0) begin : g_bad_entries
      $error("pll_rate_pick: NUM_ENTRIES out of range");
   end
   if (REQ_W > 30) begin : g_bad_req
      $error("pll_rate_pick: REQ_W too wide");
   end

   always_comb begin
      rate_entry_t e;
      int          r;
      int          d;
      int          best_d;
      found  = 1'b0;
      pick   = '0;
      best_d = 0;
      r      = int'(req);
      for (int i = 0; i < TABLE_MAX; i++) begin
         if (i < NUM_ENTRIES) begin
            e = table_entry(i);
            d = (r > int'(e.mhz)) ? r - int'(e.mhz) : int'(e.mhz) - r;
            // strict compare: an equal distance keeps the earlier entry
            if (!found || d < best_d) begin
               found  = 1'b1;
               best_d = d;
               pick   = e;
            end
         end
      end
   end

endmodule

// File: rtl/pll_word_readback.sv
module pll_word_readback
   import pll_retune_pkg::*;
#(
   parameter int REF_HZ = 33_333_333,
   parameter int FREQ_W = 34
) (
   input  logic            pd,
   input  logic            byp,
   input  logic [OD_W-1:0] od,
   input  logic [ID_W-1:0] id,
   input  logic [FB_W-1:0] fb,
   output logic [FREQ_W-1:0] freq
);

   localparam int NUM_W = $clog2(REF_HZ) + FB_W + 2;

   logic [FB_W:0]   fb1;
   logic [ID_W:0]   id1;
   logic [8:0]      den;
   logic [NUM_W-1:0] num;
   logic [NUM_W-1:0] quo;

   always_comb begin
      fb1 = {1'b0, fb} + (FB_W+1)'(1);
      id1 = {1'b0, id} + (ID_W+1)'(1);
      den = 9'(id1) << od;
      num = NUM_W'(REF_HZ) * NUM_W'({fb1, 1'b0});
      quo = num / NUM_W'(den);
      if (pd)       freq = '0;
      else if (byp) freq = FREQ_W'(REF_HZ);
      else          freq = FREQ_W'(quo);
   end

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
   parameter int LOCK_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic expire
);

   localparam int CNT_W = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;

   if (LOCK_CYC < 1) begin : g_bad_cyc
      $error("pll_lock_timer: LOCK_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   assign expire = run_q && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (arm) begin
         cnt_q <= CNT_W'(LOCK_CYC - 1);
         run_q <= 1'b1;
      end else if (expire) begin
         run_q <= 1'b0;
      end else if (run_q) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/pll_retune_ctrl.sv
module pll_retune_ctrl
   import pll_retune_pkg::*;
#(
   parameter int              REQ_W         = MHZ_W,
   parameter int              CW_W          = 32,
   parameter int              BAND_W        = 2,
   parameter int              FREQ_W        = 34,
   parameter int              REF_HZ        = 33_333_333,
   parameter int              NUM_ENTRIES   = TABLE_MAX,
   parameter int              LOCK_US       = 100,
   parameter int              CYCLES_PER_US = 50,
   parameter int              THRESH_MHZ    = 500,
   parameter bit              CORE_MODE     = 1'b1,
   parameter logic [CW_W-1:0] RESET_WORD    = CW_W'(1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [REQ_W-1:0]  req_mhz,
   input  logic [1:0]        pll_status,
   output logic              busy,
   output logic              done,
   output logic [1:0]        result,
   output logic [CW_W-1:0]   ctrl_word,
   output logic              if_div2,
   output logic [FREQ_W-1:0] freq_hz
);

   localparam int LOCK_CYC = LOCK_US * CYCLES_PER_US;

   if (CW_W < BAND_LSB + BAND_W) begin : g_bad_cw
      $error("pll_retune_ctrl: CW_W cannot hold the band field");
   end
   if (LOCK_CYC < 1) begin : g_bad_lock
      $error("pll_retune_ctrl: lock window must be at least one cycle");
   end

   state_t           state;
   logic [REQ_W-1:0] req_q;
   logic [CW_W-1:0]  ctrl_q;
   result_t          res_q;
   result_t          chk_res;
   logic             done_q;
   logic             found;
   rate_entry_t      pick;
   logic             sel_above;
   logic             expire;
   logic [CW_W-1:0]  new_word;

   pll_rate_pick #(.NUM_ENTRIES(NUM_ENTRIES), .REQ_W(REQ_W)) u_pick (
      .req   (req_q),
      .found (found),
      .pick  (pick)
   );

   pll_lock_timer #(.LOCK_CYC(LOCK_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (state == ST_WRITE),
      .expire (expire)
   );

   pll_word_readback #(.REF_HZ(REF_HZ), .FREQ_W(FREQ_W)) u_readback (
      .pd   (ctrl_q[PD_BIT]),
      .byp  (ctrl_q[BYP_BIT]),
      .od   (ctrl_q[OD_LSB +: OD_W]),
      .id   (ctrl_q[ID_LSB +: ID_W]),
      .fb   (ctrl_q[FB_LSB +: FB_W]),
      .freq (freq_hz)
   );

   assign sel_above = int'(pick.mhz) > THRESH_MHZ;

   always_comb begin
      new_word = '0;
      new_word[OD_LSB +: OD_W]     = pick.od;
      new_word[ID_LSB +: ID_W]     = pick.id;
      new_word[FB_LSB +: FB_W]     = pick.fb;
      new_word[BAND_LSB +: BAND_W] = '0;
   end

   always_comb begin
      if (!pll_status[0])     chk_res = RES_TIMEOUT;
      else if (pll_status[1]) chk_res = RES_INVALID;
      else                    chk_res = RES_OK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         req_q  <= '0;
         ctrl_q <= RESET_WORD;
         res_q  <= RES_OK;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: if (start) begin
               req_q <= req_mhz;
               state <= ST_PREP;
            end
            ST_PREP: if (!found) begin
               res_q  <= RES_INVALID;
               done_q <= 1'b1;
               state  <= ST_IDLE;
            end else begin
               state <= ST_WRITE;
            end
            ST_WRITE: begin
               ctrl_q <= new_word;
               state  <= ST_WAIT;
            end
            ST_WAIT: if (expire) state <= ST_CHECK;
            ST_CHECK: begin
               res_q  <= chk_res;
               done_q <= 1'b1;
               state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   if (CORE_MODE) begin : g_core
      logic div_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            div_q <= 1'b0;
         end else if (state == ST_PREP && found && sel_above) begin
            div_q <= 1'b1;
         end else if (state == ST_CHECK && chk_res == RES_OK && !sel_above) begin
            div_q <= 1'b0;
         end
      end
      assign if_div2 = div_q;

      // R7: divide-by-2 already selected before a high-rate word lands
      a_r7_div2_before_write: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_word != $past(ctrl_word) && sel_above) |-> $past(if_div2));

      // R8: divide-by-1 only returns with a clean completion
      a_r8_div1_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(if_div2) |-> (done && result == RES_OK));
   end else begin : g_plain
      assign if_div2 = 1'b0;
   end

   assign busy      = (state != ST_IDLE);
   assign done      = done_q;
   assign result    = res_q;
   assign ctrl_word = ctrl_q;

   // R2: fresh words never carry power-down or bypass
   a_r2_clear_pd_byp: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_word != $past(ctrl_word)) |-> (ctrl_word[BYP_BIT:PD_BIT] == 2'b00));

   // R12: completion is a single-cycle pulse
   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: the accepted request is frozen while busy
   a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(req_q));

   // R12: result only moves together with done
   a_r12_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));

endmodule

// File: tb/pll_retune_ctrl_bench.sv
module pll_retune_ctrl_bench;

   localparam int CPU   = 2;
   localparam int LUS   = 100;
   localparam int L     = CPU * LUS;
   localparam longint REF = 33333333;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        start_v [3];
   logic [10:0] req_v   [3];
   logic [1:0]  status;
   logic        busy_v  [3];
   logic        done_v  [3];
   logic [1:0]  res_v   [3];
   logic [31:0] cw_v    [3];
   logic        if_v    [3];
   logic [33:0] fr_v    [3];

   pll_retune_ctrl #(.LOCK_US(LUS), .CYCLES_PER_US(CPU), .CORE_MODE(1'b1),
      .NUM_ENTRIES(21), .RESET_WORD(32'd1)) u_pll_retune_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start_v[0]), .req_mhz(req_v[0]),
      .pll_status(status), .busy(busy_v[0]), .done(done_v[0]), .result(res_v[0]),
      .ctrl_word(cw_v[0]), .if_div2(if_v[0]), .freq_hz(fr_v[0]));

   pll_retune_ctrl #(.LOCK_US(LUS), .CYCLES_PER_US(CPU), .CORE_MODE(1'b0),
      .NUM_ENTRIES(3), .RESET_WORD(32'd2)) u_pll_retune_ctrl_alt (
      .clk(clk), .rst_n(rst_n), .start(start_v[1]), .req_mhz(req_v[1]),
      .pll_status(status), .busy(busy_v[1]), .done(done_v[1]), .result(res_v[1]),
      .ctrl_word(cw_v[1]), .if_div2(if_v[1]), .freq_hz(fr_v[1]));

   pll_retune_ctrl #(.LOCK_US(LUS), .CYCLES_PER_US(CPU), .CORE_MODE(1'b1),
      .NUM_ENTRIES(0), .RESET_WORD(32'd2)) u_pll_retune_ctrl_empty (
      .clk(clk), .rst_n(rst_n), .start(start_v[2]), .req_mhz(req_v[2]),
      .pll_status(status), .busy(busy_v[2]), .done(done_v[2]), .result(res_v[2]),
      .ctrl_word(cw_v[2]), .if_div2(if_v[2]), .freq_hz(fr_v[2]));

   int t_mhz [21];
   int t_id  [21];
   int t_fb  [21];
   int t_od  [21];

   int nvec = 0;
   int nmis = 0;
   int div_before;

   task automatic chk(input string tag, input longint act, input longint exp);
      nvec++;
      if (act !== exp) begin
         nmis++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_entry(input int i, input int m, input int a, input int f, input int o);
      t_mhz[i] = m; t_id[i] = a; t_fb[i] = f; t_od[i] = o;
   endtask

   function automatic int exp_idx(input int req, input int n);
      int best = 0;
      for (int j = 1; j < n; j++) begin
         int dj = (req > t_mhz[j]) ? req - t_mhz[j] : t_mhz[j] - req;
         int db = (req > t_mhz[best]) ? req - t_mhz[best] : t_mhz[best] - req;
         if (dj < db) best = j;
      end
      return best;
   endfunction

   function automatic int idx_of(input int mhz);
      for (int j = 0; j < 21; j++) if (t_mhz[j] == mhz) return j;
      return 0;
   endfunction

   function automatic longint exp_word(input int i);
      return (longint'(t_fb[i]) << 9) | (longint'(t_id[i]) << 4) | (longint'(t_od[i]) << 2);
   endfunction

   function automatic longint exp_freq(input longint w);
      longint fb = (w >> 9) & 127;
      longint id = (w >> 4) & 31;
      longint od = (w >> 2) & 3;
      if (w[0]) return 0;
      if (w[1]) return REF;
      return (REF * 2 * (fb + 1)) / ((id + 1) << od);
   endfunction

   // start one retune on instance k; lat = edges from acceptance to done
   task automatic run_op(input int k, input int req, output int lat);
      logic [31:0] pcw;
      logic        pif;
      @(negedge clk);
      start_v[k] = 1'b1;
      req_v[k]   = 11'(req);
      pcw = cw_v[k];
      pif = if_v[k];
      div_before = 2;
      @(posedge clk);
      @(negedge clk);
      start_v[k] = 1'b0;
      lat = 0;
      while (!done_v[k] && lat < L + 50) begin
         pcw = cw_v[k];
         pif = if_v[k];
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (cw_v[k] != pcw) div_before = int'(pif);
      end
   endtask

   task automatic main_op(input int req, input string tag);
      int lat;
      int i = exp_idx(req, 21);
      run_op(0, req, lat);
      chk({"R5 latency ", tag}, lat, L + 3);
      chk({"R6 ok ", tag}, res_v[0], 0);
      chk({"R1 R2 R4 word ", tag}, cw_v[0], exp_word(i));
      chk({"R3 freq ", tag}, fr_v[0], exp_freq(exp_word(i)));
      if (t_mhz[i] > 500) begin
         chk({"R7 div2 ", tag}, if_v[0], 1);
         if (div_before != 2) chk({"R7 order ", tag}, div_before, 1);
      end else begin
         chk({"R8 div1 ", tag}, if_v[0], 0);
      end
      @(negedge clk);
      chk({"R12 pulse ", tag}, done_v[0], 0);
      chk({"R12 held ", tag}, res_v[0], 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nmis++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
   end

   initial begin
      int lat;
      int dones;
      set_entry(0, 100, 0, 11, 3);  set_entry(1, 125, 0, 14, 3);
      set_entry(2, 133, 0, 15, 3);  set_entry(3, 150, 0, 17, 3);
      set_entry(4, 200, 1, 47, 3);  set_entry(5, 233, 1, 27, 2);
      set_entry(6, 300, 1, 35, 2);  set_entry(7, 333, 1, 39, 2);
      set_entry(8, 400, 1, 47, 2);  set_entry(9, 500, 0, 14, 1);
      set_entry(10, 600, 0, 17, 1); set_entry(11, 700, 0, 20, 1);
      set_entry(12, 800, 0, 23, 1);
      for (int j = 13; j < 21; j++) set_entry(j, 900 + 100 * (j - 13), 1, 26 + 3 * (j - 13), 0);

      for (int k = 0; k < 3; k++) begin start_v[k] = 1'b0; req_v[k] = '0; end
      status = 2'b01;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R12 reset done", done_v[0], 0);
      chk("R9 reset busy", busy_v[0], 0);
      chk("R3 reset word pd", cw_v[0], 1);
      chk("R3 freq power-down", fr_v[0], 0);
      chk("R8 reset div", if_v[0], 0);
      chk("R3 freq bypass", fr_v[1], REF);

      // sweep of requests with a clean lock
      for (int r = 0; r <= 1700; r += 7) main_op(r, "sweep");

      // ties keep the earlier entry, and clamps at the ends
      main_op(129, "tie129");  chk("R4 tie 129->125", cw_v[0], exp_word(idx_of(125)));
      main_op(175, "tie175");  chk("R4 tie 175->150", cw_v[0], exp_word(idx_of(150)));
      main_op(450, "tie450");  chk("R4 tie 450->400", cw_v[0], exp_word(idx_of(400)));
      main_op(550, "tie550");  chk("R4 tie 550->500", cw_v[0], exp_word(idx_of(500)));
      main_op(1650, "tie1650"); chk("R4 tie 1650->1600", cw_v[0], exp_word(idx_of(1600)));
      main_op(0, "low");       chk("R4 floor 0->100", cw_v[0], exp_word(idx_of(100)));
      main_op(2047, "high");   chk("R4 ceil 2047->1600", cw_v[0], exp_word(idx_of(1600)));

      // outcome codes and divider hold on failure
      status = 2'b00;
      run_op(0, 300, lat);
      chk("R6 timeout", res_v[0], 1);
      chk("R8 div held on timeout", if_v[0], 1);
      chk("R2 word written on timeout", cw_v[0], exp_word(idx_of(300)));
      status = 2'b10;
      run_op(0, 233, lat);
      chk("R6 error ignored without lock", res_v[0], 1);
      chk("R8 div held", if_v[0], 1);
      status = 2'b11;
      run_op(0, 300, lat);
      chk("R6 invalid", res_v[0], 2);
      chk("R8 div held on invalid", if_v[0], 1);
      status = 2'b01;
      run_op(0, 300, lat);
      chk("R6 ok after errors", res_v[0], 0);
      chk("R8 div released on ok", if_v[0], 0);

      // start held through a whole retune with other request data
      @(negedge clk);
      start_v[0] = 1'b1;
      req_v[0] = 11'd800;
      @(posedge clk);
      @(negedge clk);
      req_v[0] = 11'd100;
      lat = 0;
      while (!done_v[0] && lat < L + 50) begin
         @(posedge clk); lat++; @(negedge clk);
      end
      start_v[0] = 1'b0;
      chk("R9 latency with start held", lat, L + 3);
      chk("R9 first request kept", cw_v[0], exp_word(idx_of(800)));
      chk("R9 result", res_v[0], 0);
      dones = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (done_v[0]) dones++;
      end
      chk("R9 no second done", dones, 0);
      chk("R9 idle after", busy_v[0], 0);

      // plain variant with a short table
      run_op(1, 1000, lat);
      chk("R4 short table 1000->133", cw_v[1], exp_word(2));
      chk("R3 short table freq", fr_v[1], exp_freq(exp_word(2)));
      chk("R11 no divider", if_v[1], 0);
      run_op(1, 129, lat);
      chk("R4 short tie 129->125", cw_v[1], exp_word(1));
      chk("R11 no divider low", if_v[1], 0);
      run_op(1, 130, lat);
      chk("R4 short 130->133", cw_v[1], exp_word(2));

      // empty table
      run_op(2, 500, lat);
      chk("R10 empty latency", lat, 1);
      chk("R10 empty result", res_v[2], 2);
      chk("R10 empty no write", cw_v[2], 2);
      chk("R10 empty freq", fr_v[2], REF);
      chk("R10 empty div", if_v[2], 0);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
   end

endmodule